// File: doc/BRIEF.md
# Ready-Latency Packet Stream Adapter

This block connects a packet source that uses a plain valid/ready handshake to a transmit sink whose ready signal works with a fixed delay. On the source side, a beat moves at a rising clock edge when both `in_valid` and `in_ready` are high. Each beat carries a data word and start-of-packet and end-of-packet marks. On the sink side, a high `sink_ready` in cycle n lets the adapter present exactly one beat in cycle n + `READY_LAT`. There is no back-pressure after that point: the sink takes the beat whenever `out_valid` is high.

Accepted beats wait in a small FIFO until the sink grants a slot. The adapter keeps a short shift register of sampled ready values. It presents a beat only when the bit leaving that register is set. This means a grant is never wasted while a beat is stored, and a beat never goes out in a cycle the sink has not granted. Beats leave in arrival order, so every packet keeps the beat count it arrived with.

After reset is released, the adapter keeps both sides closed for `HOLD_CYC` cycles and ignores `sink_ready` during that time. Cycles are counted from cycle 0, the first cycle in which `rst_n` is high. A `sink_ready` seen while reset is asserted also has no effect.

Top module: `rl_stream_adapter`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sop`, `out_eop` and `in_ready` are all low, whatever the level of `sink_ready`.
- R2: `in_ready` is low in cycles 0 to `HOLD_CYC`-1 after reset release. `sink_ready` in those cycles has no effect. No beat is issued before cycle `HOLD_CYC`+`READY_LAT`.
- R3: `out_valid` is high in cycle c only if `sink_ready` was high in cycle c-`READY_LAT` and c-`READY_LAT` is at least `HOLD_CYC`.
- R4: In every cycle that meets the grant condition of R3 while the FIFO holds at least one beat accepted in an earlier cycle, `out_valid` is high.
- R5: Beats leave in the order they were accepted, with data, start mark and end mark unchanged. No beat is repeated.
- R6: `out_sop` and `out_eop` are low in every cycle where `out_valid` is low.
- R7: From cycle `HOLD_CYC` on, `in_ready` is high unless the FIFO holds `FIFO_DEPTH` beats and the current cycle is not a grant cycle. A beat accepted at an edge is never issued in the cycle before that edge.
- R8: The FIFO never overflows or underflows. Once the source stops and grants continue, the number of beats issued equals the number accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W | Source beat data |
| in_valid | input | 1 | Source beat present |
| in_sop | input | 1 | Source beat is first of its packet (meaningful with `in_valid`) |
| in_eop | input | 1 | Source beat is last of its packet (meaningful with `in_valid`) |
| in_ready | output | 1 | Adapter accepts a beat at the next edge |
| sink_ready | input | 1 | Sink grant; takes effect `READY_LAT` cycles later |
| out_data | output | DATA_W | Issued beat data |
| out_valid | output | 1 | Beat issued this cycle |
| out_sop | output | 1 | Issued beat starts a packet |
| out_eop | output | 1 | Issued beat ends a packet |

## Verification
The hardest case to reach is a full FIFO that receives a grant in the same cycle as a new source beat. Only in that case may `in_ready` stay high at full occupancy. It needs grants that were sampled `READY_LAT` cycles earlier to line up with a filled buffer. The stimulus table first starves the sink while the source streams, which fills the FIFO. It then applies alternating and sparse ready masks, so grants fall at every point of a full buffer. A second reset is applied with a loaded FIFO and `sink_ready` held high. This shows that stale grants and the hold-off window both behave as specified.

// File: rtl/rl_pkg.sv
// Package: shared constants and types for the ready-latency stream adapter.
// Assumes: nothing; holds only compile-time items.
package rl_pkg;

    // Smallest quiet window after reset that the sink side tolerates.
    localparam int unsigned RL_HOLD_MIN = 2;

    // Largest supported sink ready latency.
    localparam int unsigned RL_LAT_MAX = 2;

    // Packet framing marks stored next to each data word.
    typedef struct packed {
        logic sop;
        logic eop;
    } rl_mark_t;

    localparam int unsigned RL_MARK_W = $bits(rl_mark_t);

endpackage

// File: rtl/rl_startup_gate.sv
// Module: rl_startup_gate
// Counts HOLD_CYC cycles after synchronous reset release, then raises
// open_o and keeps it high until the next reset.
// Assumes: HOLD_CYC >= 1; rst_n is synchronous to clk.
module rl_startup_gate #(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_o
);

    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    // Purpose: count cycles since reset release, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign open_o = (cnt_q == LIMIT);

    AST_GATE_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> open_o); // R2

endmodule

// File: rtl/rl_grant_pipe.sv
// Module: rl_grant_pipe
// Delays the sampled sink ready by LAT cycles. grant_o is high in the
// cycle where the sink has promised to take a beat.
// Assumes: LAT is 1 or 2; ready is only sampled while open_i is high.
module rl_grant_pipe #(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic sink_ready_i,
    output logic grant_o
);

    logic [LAT-1:0] sr_q;
    logic           sample;

    assign sample = open_i & sink_ready_i;

    generate
        if (LAT == 1) begin : g_lat_one
            // Purpose: single-stage register of the gated ready.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sr_q <= '0;
                end else begin
                    sr_q <= sample;
                end
            end
        end else begin : g_lat_multi
            // Purpose: shift the gated ready through LAT stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sr_q <= '0;
                end else begin
                    sr_q <= {sr_q[LAT-2:0], sample};
                end
            end
        end
    endgenerate

    assign grant_o = sr_q[LAT-1];

    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(sample, LAT)); // R3

endmodule

// File: rtl/rl_beat_fifo.sv
// Module: rl_beat_fifo
// Holds up to DEPTH beats in arrival order. Push and pop may both occur
// in the same cycle, including when the FIFO is full.
// Assumes: the caller never pushes into a full FIFO without popping, and
// never pops an empty one. Storage words carry no reset.
module rl_beat_fifo #(
    parameter int unsigned WIDTH = 66,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_q;
    logic [PW-1:0]    rd_q;
    logic [CW-1:0]    cnt_q;

    // Purpose: write the incoming beat into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_q] <= wdata;
        end
    end

    // Purpose: advance the read and write pointers with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) begin
                wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
        end
    end

    // Purpose: track the number of stored beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem_q[rd_q];
    assign full  = (cnt_q == CAP);
    assign empty = (cnt_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8

endmodule

// File: rtl/rl_stream_adapter.sv
// Module: rl_stream_adapter (top)
// Bridges a zero-latency valid/ready packet source to a sink whose ready
// takes effect READY_LAT cycles later. Accepted beats are buffered and
// issued only in granted cycles. Both sides stay closed for HOLD_CYC
// cycles after reset release.
// Assumes: the sink takes every beat presented with out_valid; the source
// delivers well-formed packets; rst_n is synchronous.
module rl_stream_adapter
    import rl_pkg::*;
#(
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned READY_LAT  = 2,
    parameter int unsigned FIFO_DEPTH = READY_LAT + 2,
    parameter int unsigned HOLD_CYC   = RL_HOLD_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              in_ready,
    input  logic              sink_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop
);

    localparam int unsigned BEAT_W = DATA_W + RL_MARK_W;

    generate
        if (!(DATA_W == 64 || DATA_W == 128)) begin : g_bad_width
            $error("rl_stream_adapter: DATA_W must be 64 or 128");
        end
        if (READY_LAT < 1 || READY_LAT > RL_LAT_MAX) begin : g_bad_lat
            $error("rl_stream_adapter: READY_LAT must be 1 or 2");
        end
    endgenerate

    logic              gate_open;
    logic              grant;
    logic              fifo_full;
    logic              fifo_empty;
    logic              push;
    logic              pop;
    logic [BEAT_W-1:0] wr_beat;
    logic [BEAT_W-1:0] head;
    rl_mark_t          in_mark;
    rl_mark_t          head_mark;

    rl_startup_gate #(
        .HOLD_CYC (HOLD_CYC)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_o (gate_open)
    );

    rl_grant_pipe #(
        .LAT (READY_LAT)
    ) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (gate_open),
        .sink_ready_i (sink_ready),
        .grant_o      (grant)
    );

    rl_beat_fifo #(
        .WIDTH (BEAT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wr_beat),
        .pop   (pop),
        .rdata (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Purpose: pack the source beat with its framing marks.
    always_comb begin
        in_mark.sop = in_sop;
        in_mark.eop = in_eop;
        wr_beat     = {in_mark, in_data};
    end

    // Purpose: issue the head beat in granted cycles and open the source side.
    always_comb begin
        head_mark = rl_mark_t'(head[BEAT_W-1 -: RL_MARK_W]);
        out_valid = grant & ~fifo_empty;
        out_data  = head[DATA_W-1:0];
        out_sop   = out_valid & head_mark.sop;
        out_eop   = out_valid & head_mark.eop;
        in_ready  = gate_open & (~fifo_full | grant);
        push      = in_valid & in_ready;
        pop       = out_valid;
    end

    AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> (!out_valid && !in_ready)); // R2
    AST_VALID_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sink_ready, READY_LAT)); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !out_valid) |-> !in_ready); // R7

endmodule

// File: tb/rl_stream_adapter_tb.sv
`timescale 1ns/1ps
module rl_stream_adapter_tb_top;

    localparam int unsigned DW    = 64;
    localparam int unsigned LAT   = 2;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned HOLD  = 2;
    localparam int unsigned SBN   = 512;

    // Vector: {source valid mask[15:0], sink ready mask[15:0], packet length[3:0]}
    localparam int unsigned NVEC = 8;
    localparam logic [35:0] VEC [NVEC] = '{
        {16'hFFFF, 16'hFFFF, 4'd1},
        {16'hFFFF, 16'hAAAA, 4'd3},
        {16'h5555, 16'hFFFF, 4'd4},
        {16'hFFFF, 16'h0000, 4'd2},
        {16'h0000, 16'hFFFF, 4'd2},
        {16'hFFFF, 16'h3333, 4'd5},
        {16'hF0F0, 16'h0F0F, 4'd2},
        {16'hFFFF, 16'h8001, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          in_ready;
    logic          sink_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_sop;
    logic          out_eop;

    always #4 clk = ~clk;   // 125 MHz

    rl_stream_adapter #(
        .DATA_W     (DW),
        .READY_LAT  (LAT),
        .FIFO_DEPTH (DEPTH),
        .HOLD_CYC   (HOLD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_ready   (in_ready),
        .sink_ready (sink_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    int unsigned   n_chk = 0;
    int unsigned   n_fail = 0;
    bit            done = 1'b0;
    int            cyc = 0;
    logic          hist [8];
    logic [DW+1:0] sb [SBN];
    int unsigned   sb_wr = 0;
    int unsigned   sb_rd = 0;
    int unsigned   n_in = 0;
    int unsigned   n_out = 0;
    int unsigned   beat_idx = 0;
    int unsigned   pkt_len = 1;
    logic [31:0]   seq = 32'h1000;

    task automatic chk(input string tag, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Current source beat contents derived from the packet position.
    task automatic load_beat(input int unsigned len);
        if (beat_idx == 0) pkt_len = (len == 0) ? 1 : len;
        in_data = {(DW/32){seq ^ 32'h5A00_0000}};
        in_sop  = (beat_idx == 0);
        in_eop  = (beat_idx == pkt_len - 1);
    endtask

    // Sample and check one cycle, then drive the inputs for it.
    task automatic cycle_body(input logic v, input logic r, input int unsigned len);
        logic legal;
        logic rdy_now;
        int   sb_cnt;
        sb_cnt  = int'(sb_wr - sb_rd);
        legal   = (cyc >= int'(HOLD + LAT)) && hist[(cyc - int'(LAT)) % 8];
        rdy_now = in_ready;
        if (cyc < int'(HOLD)) chk("R2 in_ready closed", {1'b0, 1'b0, DW'(in_ready)}, '0);
        if (cyc < int'(HOLD + LAT)) chk("R2 no early beat", {1'b0, 1'b0, DW'(out_valid)}, '0);
        if (!legal) chk("R3 valid only in grant cycle", {1'b0, 1'b0, DW'(out_valid)}, '0);
        else chk("R4 grant used", {1'b0, 1'b0, DW'(out_valid)}, {1'b0, 1'b0, DW'(sb_cnt > 0)});
        if (!out_valid) chk("R6 marks need valid", {1'b0, 1'b0, DW'({out_sop, out_eop})}, '0);
        chk("R7 in_ready", {1'b0, 1'b0, DW'(in_ready)},
            {1'b0, 1'b0, DW'((cyc >= int'(HOLD)) && ((sb_cnt < int'(DEPTH)) || legal))});
        if (out_valid) begin
            chk("R5 beat order", {out_sop, out_eop, out_data}, sb[sb_rd % SBN]);
            sb_rd++;
            n_out++;
        end
        // drive cycle inputs
        load_beat(len);
        in_valid   = v;
        sink_ready = r;
        hist[cyc % 8] = r;
        if (v && rdy_now) begin
            sb[sb_wr % SBN] = {in_sop, in_eop, in_data};
            sb_wr++;
            n_in++;
            seq = seq + 1;
            beat_idx = in_eop ? 0 : beat_idx + 1;
        end
        cyc++;
    endtask

    task automatic step(input logic v, input logic r, input int unsigned len);
        @(negedge clk);
        cycle_body(v, r, len);
    endtask

    task automatic do_reset(input int unsigned n);
        @(negedge clk);
        rst_n      = 1'b0;
        sink_ready = 1'b1;
        in_valid   = 1'b1;
        for (int k = 0; k < int'(n); k++) begin
            @(negedge clk);
            chk("R1 outputs low in reset",
                {out_sop, out_eop, DW'({out_valid, in_ready})}, '0);
        end
        sb_rd = sb_wr;
        beat_idx = 0;
        cyc = 0;
        rst_n = 1'b1;
        cycle_body(1'b1, 1'b1, 3);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) hist[i] = 1'b0;
        do_reset(3);
        // Table of stimulus patterns walked by one loop.
        for (int e = 0; e < int'(NVEC); e++) begin
            for (int b = 15; b >= 0; b--) begin
                step(VEC[e][20 + b], VEC[e][4 + b], int'(VEC[e][3:0]));
            end
        end
        // Finish the open packet, then drain.
        while (beat_idx != 0) step(1'b1, 1'b1, 1);
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1);
        chk("R8 all beats issued", {2'b0, DW'(n_out)}, {2'b0, DW'(n_in)});
        chk("R8 buffer empty", {2'b0, DW'(sb_wr - sb_rd)}, '0);
        // Directed: fill the buffer with no grants, then reset with ready high.
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 2);
        chk("R7 source blocked when full", {1'b0, 1'b0, DW'(in_ready)}, '0);
        do_reset(4);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 2);
        // Directed: full buffer with one isolated grant.
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 3);
        step(1'b1, 1'b1, 3);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 3);
        while (beat_idx != 0) step(1'b1, 1'b1, 1);
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1);
        chk("R8 drained after directed", {2'b0, DW'(sb_wr - sb_rd)}, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule